// File: doc/BRIEF.md
# Linked-Descriptor Byte Stream DMA Engine

This engine moves bytes between a memory request port and a byte-wide peripheral stream. It follows a chain of 16-byte descriptors held in memory. Each descriptor names a buffer, a byte count and the address of the next descriptor. Software loads a chain pointer, picks a direction and sets a run bit. The engine then fetches each descriptor, moves its bytes one at a time and follows the branch pointer. It stops at the descriptor flagged as last, or at the first fault.

Every run ends with a 4-bit event code in the channel control register. The code distinguishes success, a stalled peripheral in either direction, a failed descriptor fetch, a failed buffer access and an early stop signalled by the peripheral. The end of a run also sets an interrupt status bit, which is gated by an enable bit onto the interrupt line.

The register slave has six word slots, selected by `regAddr`:

| Slot | Register | Contents |
|------|----------|----------|
| 0 | global control | engine enable in bit 0; soft reset on write of bit 8 |
| 1 | interrupt enable | bit 0 |
| 2 | interrupt status | bit 0 |
| 3 | chain pointer | byte address of the first descriptor |
| 4 | channel control | event code in bits 3:0, run in bit 7, direction in bit 22 |
| 5 | stall timeout | limit in cycles |

Top module: `chain_dma`

## Requirements
- R1: After reset, the global control, interrupt enable, interrupt status, chain pointer and channel control registers read 0, the timeout register reads its default of 16, and `irq` is low.
- R2: Bit 0 of global control reads back as written. A write to channel control that sets the run bit (bit 7) starts the engine only while this enable bit is 1. With the enable bit at 0, run stays 0.
- R3: A write to global control with bit 8 set aborts any run. It also clears the run bit, the event code and the interrupt status. Bit 0 of the same write sets the enable bit.
- R4: A descriptor is three used words, read from the descriptor's own address plus 0, 4 and 8: flags, buffer address and next-descriptor address. In flags, bit 31 marks the last descriptor, bit 30 must be 1, and bits 15:0 give the byte count. Descriptors are processed in chain order, and a count of 0 moves no bytes.
- R5: Channel control bit 22 selects the direction. When it is 0, buffer bytes are read in rising address order and offered on `txData` with `txValid`. When it is 1, bytes accepted on `rxData` with `rxReady` are written to rising buffer addresses. `txValid` and `rxReady` are never high together, and `txData` holds steady while a byte waits.
- R6: After the last descriptor moves its full count, the event code becomes 15, the run bit clears and the interrupt status sets.
- R7: In direction 0, if `txReady` stays low for as many consecutive cycles as the timeout register holds, the run stops with event code 1.
- R8: In direction 1, if `rxValid` stays low for as many consecutive cycles as the timeout register holds, the run stops with event code 2.
- R9: If `periphEnd` is high while the engine is between bytes and the chain is not finished, the run stops with event code 5.
- R10: An error response to a descriptor fetch, or a flags word with bit 30 clear, stops the run with event code 3.
- R11: An error response to a buffer read or a buffer write stops the run with event code 4.
- R12: The interrupt status is cleared by writing 1 to bit 0 of its register. `irq` is high exactly when both the status and the interrupt enable bit are 1.
- R13: Writing channel control with the value 0 while the engine is idle clears the event code to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 3 | Register slot select |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Read data of the selected slot (combinational) |
| memReq | output | 1 | Memory request, held until acknowledged |
| memWe | output | 1 | Memory request is a byte write |
| memAddr | output | ADDR_W | Memory byte address |
| memWdata | output | 8 | Byte to write |
| memRdata | input | 32 | Read data; the addressed byte is in bits 7:0 |
| memAck | input | 1 | Memory request completes this cycle |
| memErr | input | 1 | Completing request failed |
| txValid | output | 1 | Byte offered to the peripheral |
| txReady | input | 1 | Peripheral accepts the offered byte |
| txData | output | 8 | Outgoing byte |
| rxValid | input | 1 | Peripheral offers a byte |
| rxReady | output | 1 | Engine accepts the offered byte |
| rxData | input | 8 | Incoming byte |
| periphEnd | input | 1 | Peripheral requests the transfer to end |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle, the assertions check these properties: the two stream directions never handshake together; memory writes occur only in direction 1; an offered byte stays steady until taken; a run starts only with the engine enabled; a run that stops without a soft reset always sets the status; and the status clear and the zero write to channel control take effect. The bench scenarios are needed for the rest: byte order across a chain, the data landing in memory, the event code chosen for each fault, the stall timeout, and the abort behaviour of soft reset.

// File: rtl/chain_dma_pkg.sv
package chain_dma_pkg;

  localparam int RG_W = 3;
  localparam logic [RG_W-1:0] RG_GCTRL = 3'd0;
  localparam logic [RG_W-1:0] RG_IE    = 3'd1;
  localparam logic [RG_W-1:0] RG_IS    = 3'd2;
  localparam logic [RG_W-1:0] RG_PTR   = 3'd3;
  localparam logic [RG_W-1:0] RG_CCR   = 3'd4;
  localparam logic [RG_W-1:0] RG_TMO   = 3'd5;

  localparam int GC_EN   = 0;
  localparam int GC_SRST = 8;
  localparam int CC_RUN  = 7;
  localparam int CC_DIR  = 22;

  typedef enum logic [3:0] {
    EV_NONE  = 4'd0,
    EV_UNDER = 4'd1,
    EV_OVER  = 4'd2,
    EV_DESC  = 4'd3,
    EV_DATA  = 4'd4,
    EV_EARLY = 4'd5,
    EV_OK    = 4'd15
  } evCode_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_CHECK, ST_MRD, ST_PSEND, ST_PWAIT, ST_MWR, ST_NEXT
  } dmaState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       loadPtr;
    logic       capWord;
    logic [1:0] wordIdx;
    logic       dataAddr;
    logic       capByte;
    logic       byteFromRx;
    logic       stepByte;
    logic       followNext;
    logic       runTimer;
  } dpStrobe_t;

endpackage

// File: rtl/chain_dma_dp.sv
module chain_dma_dp
  import chain_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int TMO_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              softRst,
  input  dpStrobe_t         stb,
  input  logic [ADDR_W-1:0] descPtr,
  input  logic [TMO_W-1:0]  tmoLimit,
  input  logic [31:0]       memRdata,
  input  logic [7:0]        rxData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWdata,
  output logic [7:0]        txData,
  output logic              lastDesc,
  output logic              fmtOk,
  output logic              remainZero,
  output logic              remainOne,
  output logic              timeoutHit
);

  localparam int LAST_BIT = 31;
  localparam int FMT_BIT  = 30;

  logic [ADDR_W-1:0] curDesc, bufAddr, nextAddr;
  logic [CNT_W-1:0]  remain;
  logic              lastFlag, fmtFlag;
  logic [7:0]        dataByte;
  logic [TMO_W-1:0]  timer;

  always_ff @(posedge clk) begin
    if (!rstN || softRst) begin
      curDesc  <= '0;
      bufAddr  <= '0;
      nextAddr <= '0;
      remain   <= '0;
      lastFlag <= 1'b0;
      fmtFlag  <= 1'b0;
      dataByte <= '0;
      timer    <= '0;
    end else begin
      if (stb.loadPtr)    curDesc <= descPtr;
      if (stb.followNext) curDesc <= nextAddr;
      if (stb.capWord) begin
        case (stb.wordIdx)
          2'd0: begin
            lastFlag <= memRdata[LAST_BIT];
            fmtFlag  <= memRdata[FMT_BIT];
            remain   <= memRdata[CNT_W-1:0];
          end
          2'd1:    bufAddr  <= memRdata[ADDR_W-1:0];
          2'd2:    nextAddr <= memRdata[ADDR_W-1:0];
          default: ;
        endcase
      end
      if (stb.capByte) dataByte <= stb.byteFromRx ? rxData : memRdata[7:0];
      if (stb.stepByte) begin
        bufAddr <= bufAddr + 1'b1;
        remain  <= remain - 1'b1;
      end
      timer <= stb.runTimer ? timer + 1'b1 : '0;
    end
  end

  assign memAddr    = stb.dataAddr ? bufAddr
                                   : curDesc + ADDR_W'({stb.wordIdx, 2'b00});
  assign memWdata   = dataByte;
  assign txData     = dataByte;
  assign lastDesc   = lastFlag;
  assign fmtOk      = fmtFlag;
  assign remainZero = (remain == '0);
  assign remainOne  = (remain == CNT_W'(1));
  assign timeoutHit = (timer == TMO_W'(tmoLimit - 1'b1));

endmodule

// File: rtl/chain_dma_ctrl.sv
module chain_dma_ctrl
  import chain_dma_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       softRst,
  input  logic       ccrWr,
  input  logic       wrRun,
  input  logic       wrDir,
  input  logic       wrZero,
  input  logic       engEn,
  input  logic       isClr,
  input  logic       memAck,
  input  logic       memErr,
  input  logic       txReady,
  input  logic       rxValid,
  input  logic       periphEnd,
  input  logic       lastDesc,
  input  logic       fmtOk,
  input  logic       remainZero,
  input  logic       remainOne,
  input  logic       timeoutHit,
  output dpStrobe_t  stb,
  output logic       memReq,
  output logic       memWe,
  output logic       txValid,
  output logic       rxReady,
  output logic       runBit,
  output logic       dirBit,
  output logic [3:0] eventCode,
  output logic       intSts,
  output logic       busy
);

  dmaState_e state, nextState;
  logic [1:0] fetchIdx, nextIdx;
  logic       doFinish;
  evCode_e    finCode;
  logic       startReq;

  assign busy     = (state != ST_IDLE);
  assign startReq = !busy && ccrWr && wrRun && engEn;

  always_comb begin
    stb       = '0;
    memReq    = 1'b0;
    memWe     = 1'b0;
    txValid   = 1'b0;
    rxReady   = 1'b0;
    nextState = state;
    nextIdx   = fetchIdx;
    doFinish  = 1'b0;
    finCode   = EV_NONE;
    stb.wordIdx = fetchIdx;
    case (state)
      ST_IDLE: begin
        stb.loadPtr = startReq;
        if (startReq) begin
          nextState = ST_FETCH;
          nextIdx   = 2'd0;
        end
      end
      ST_FETCH: begin
        memReq = 1'b1;
        if (memAck) begin
          if (memErr) begin
            doFinish = 1'b1; finCode = EV_DESC;
          end else begin
            stb.capWord = 1'b1;
            if (fetchIdx == 2'd2) nextState = ST_CHECK;
            else nextIdx = fetchIdx + 2'd1;
          end
        end
      end
      ST_CHECK: begin
        if (!fmtOk) begin
          doFinish = 1'b1; finCode = EV_DESC;
        end else if (periphEnd) begin
          doFinish = 1'b1; finCode = EV_EARLY;
        end else if (remainZero) nextState = ST_NEXT;
        else nextState = dirBit ? ST_PWAIT : ST_MRD;
      end
      ST_MRD: begin
        memReq = 1'b1;
        stb.dataAddr = 1'b1;
        if (memAck) begin
          if (memErr) begin
            doFinish = 1'b1; finCode = EV_DATA;
          end else begin
            stb.capByte = 1'b1;
            nextState   = ST_PSEND;
          end
        end
      end
      ST_PSEND: begin
        txValid = !periphEnd;
        if (periphEnd) begin
          doFinish = 1'b1; finCode = EV_EARLY;
        end else if (txReady) begin
          stb.stepByte = 1'b1;
          nextState = remainOne ? ST_NEXT : ST_MRD;
        end else begin
          stb.runTimer = 1'b1;
          if (timeoutHit) begin
            doFinish = 1'b1; finCode = EV_UNDER;
          end
        end
      end
      ST_PWAIT: begin
        rxReady = !periphEnd;
        if (periphEnd) begin
          doFinish = 1'b1; finCode = EV_EARLY;
        end else if (rxValid) begin
          stb.capByte    = 1'b1;
          stb.byteFromRx = 1'b1;
          nextState      = ST_MWR;
        end else begin
          stb.runTimer = 1'b1;
          if (timeoutHit) begin
            doFinish = 1'b1; finCode = EV_OVER;
          end
        end
      end
      ST_MWR: begin
        memReq = 1'b1;
        memWe  = 1'b1;
        stb.dataAddr = 1'b1;
        if (memAck) begin
          if (memErr) begin
            doFinish = 1'b1; finCode = EV_DATA;
          end else begin
            stb.stepByte = 1'b1;
            nextState = remainOne ? ST_NEXT : ST_PWAIT;
          end
        end
      end
      ST_NEXT: begin
        if (lastDesc) begin
          doFinish = 1'b1; finCode = EV_OK;
        end else if (periphEnd) begin
          doFinish = 1'b1; finCode = EV_EARLY;
        end else begin
          stb.followNext = 1'b1;
          nextState = ST_FETCH;
          nextIdx   = 2'd0;
        end
      end
      default: nextState = ST_IDLE;
    endcase
    if (doFinish) nextState = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dirBit <= 1'b0;
    end else if (!busy && ccrWr) begin
      dirBit <= wrDir;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || softRst) begin
      state     <= ST_IDLE;
      fetchIdx  <= 2'd0;
      runBit    <= 1'b0;
      eventCode <= EV_NONE;
      intSts    <= 1'b0;
    end else begin
      state    <= nextState;
      fetchIdx <= nextIdx;
      if (!busy && ccrWr && wrZero) eventCode <= EV_NONE;
      if (startReq) begin
        runBit    <= 1'b1;
        eventCode <= EV_NONE;
      end
      if (doFinish) begin
        runBit    <= 1'b0;
        eventCode <= finCode;
        intSts    <= 1'b1;
      end else if (isClr) begin
        intSts <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/chain_dma.sv
module chain_dma
  import chain_dma_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int CNT_W    = 16,
  parameter int TMO_W    = 16,
  parameter int TMO_INIT = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [2:0]        regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWdata,
  input  logic [31:0]       memRdata,
  input  logic              memAck,
  input  logic              memErr,
  output logic              txValid,
  input  logic              txReady,
  output logic [7:0]        txData,
  input  logic              rxValid,
  output logic              rxReady,
  input  logic [7:0]        rxData,
  input  logic              periphEnd,
  output logic              irq
);

  logic              engEn, intEn, softRst, ccrWr, isClr;
  logic [ADDR_W-1:0] descPtr;
  logic [TMO_W-1:0]  tmoLimit;
  logic              runBit, dirBit, intSts, busy;
  logic [3:0]        eventCode;
  logic              lastDesc, fmtOk, remainZero, remainOne, timeoutHit;
  dpStrobe_t         stb;

  assign softRst = regWr && (regAddr == RG_GCTRL) && regWdata[GC_SRST];
  assign ccrWr   = regWr && (regAddr == RG_CCR);
  assign isClr   = regWr && (regAddr == RG_IS) && regWdata[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      engEn    <= 1'b0;
      intEn    <= 1'b0;
      descPtr  <= '0;
      tmoLimit <= TMO_W'(TMO_INIT);
    end else if (regWr) begin
      case (regAddr)
        RG_GCTRL: engEn    <= regWdata[GC_EN];
        RG_IE:    intEn    <= regWdata[0];
        RG_PTR:   descPtr  <= regWdata[ADDR_W-1:0];
        RG_TMO:   tmoLimit <= regWdata[TMO_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (regAddr)
      RG_GCTRL: regRdata = {31'b0, engEn};
      RG_IE:    regRdata = {31'b0, intEn};
      RG_IS:    regRdata = {31'b0, intSts};
      RG_PTR:   regRdata = 32'(descPtr);
      RG_CCR:   regRdata = {9'b0, dirBit, 14'b0, runBit, 3'b0, eventCode};
      RG_TMO:   regRdata = 32'(tmoLimit);
      default:  regRdata = '0;
    endcase
  end

  assign irq = intSts && intEn;

  chain_dma_ctrl u_ctrl (
    .clk, .rstN, .softRst, .ccrWr,
    .wrRun(regWdata[CC_RUN]), .wrDir(regWdata[CC_DIR]), .wrZero(regWdata == '0),
    .engEn, .isClr, .memAck, .memErr, .txReady, .rxValid, .periphEnd,
    .lastDesc, .fmtOk, .remainZero, .remainOne, .timeoutHit,
    .stb, .memReq, .memWe, .txValid, .rxReady,
    .runBit, .dirBit, .eventCode, .intSts, .busy
  );

  chain_dma_dp #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .TMO_W(TMO_W)) u_dp (
    .clk, .rstN, .softRst, .stb, .descPtr, .tmoLimit, .memRdata, .rxData,
    .memAddr, .memWdata, .txData, .lastDesc, .fmtOk, .remainZero, .remainOne,
    .timeoutHit
  );

endmodule

// File: rtl/chain_dma_chk.sv
module chain_dma_chk (
  input logic        clk,
  input logic        rstN,
  input logic        regWr,
  input logic [2:0]  regAddr,
  input logic [31:0] regWdata,
  input logic        memReq,
  input logic        memWe,
  input logic        txValid,
  input logic        txReady,
  input logic [7:0]  txData,
  input logic        rxReady,
  input logic        irq,
  input logic        runBit,
  input logic        engEn,
  input logic        dirBit,
  input logic [3:0]  eventCode,
  input logic        intSts,
  input logic        busy
);

  logic srNow, isW1c, ccrZero;
  assign srNow   = regWr && (regAddr == 3'd0) && regWdata[8];
  assign isW1c   = regWr && (regAddr == 3'd2) && regWdata[0] && !busy;
  assign ccrZero = regWr && (regAddr == 3'd4) && (regWdata == 32'd0) && !busy;

  // R6
  fin_sets_status_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(runBit) && !$past(srNow)) |-> intSts);

  // R2
  run_needs_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(runBit) |-> engEn);

  // R5
  one_dir_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(txValid && rxReady));

  // R5
  mem_write_dir_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe) |-> dirBit);

  // R5
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(txValid && !txReady) && txValid) |-> $stable(txData));

  // R12
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(isW1c) |-> (!intSts && !irq));

  // R13
  zero_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(ccrZero) |-> (eventCode == 4'd0));

endmodule

bind chain_dma chain_dma_chk u_chk (.*);

// File: tb/chain_dma_bench.sv
module chain_dma_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        memReq, memWe, memAck, memErr;
  logic [31:0] memAddr, memRdata;
  logic [7:0]  memWdata;
  logic        txValid, txReady = 1'b0;
  logic [7:0]  txData;
  logic        rxValid, rxReady;
  logic [7:0]  rxData;
  logic        periphEnd = 1'b0;
  logic        irq;

  int checks = 0;
  int errors = 0;

  logic [7:0] mem [0:1023];
  logic [9:0] ma;
  logic [7:0] sink [0:255];
  int         sinkCnt = 0;
  logic [7:0] srcMem [0:255];
  int         srcIdx = 0;
  int         srcEnd = 0;
  logic       rxOn = 1'b0;

  always #4 clk = ~clk;

  chain_dma u_chain_dma (
    .clk, .rstN, .regWr, .regAddr, .regWdata, .regRdata,
    .memReq, .memWe, .memAddr, .memWdata, .memRdata, .memAck, .memErr,
    .txValid, .txReady, .txData, .rxValid, .rxReady, .rxData,
    .periphEnd, .irq
  );

  // memory: answers in the request cycle; addresses at 0x400 and above fail
  assign ma       = memAddr[9:0];
  assign memAck   = memReq;
  assign memErr   = memReq && (memAddr >= 32'h400);
  assign memRdata = {mem[ma + 10'd3], mem[ma + 10'd2], mem[ma + 10'd1], mem[ma]};

  assign rxValid = rxOn && (srcIdx < srcEnd);
  assign rxData  = srcMem[srcIdx[7:0]];

  always @(posedge clk) begin
    if (memReq && memWe && !memErr) mem[ma] <= memWdata;
    if (txValid && txReady) begin
      sink[sinkCnt[7:0]] <= txData;
      sinkCnt <= sinkCnt + 1;
    end
    if (rxValid && rxReady) srcIdx <= srcIdx + 1;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 1'b0; regWdata = '0;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk);
    regAddr = a;
    #1 v = regRdata;
  endtask

  task automatic putWord(input int a, input logic [31:0] w);
    for (int k = 0; k < 4; k++) mem[a + k] = w[8*k +: 8];
  endtask

  task automatic putDesc(input int a, input logic [31:0] flags,
                         input logic [31:0] buf0, input logic [31:0] nxt);
    putWord(a, flags); putWord(a + 4, buf0); putWord(a + 8, nxt); putWord(a + 12, 0);
  endtask

  task automatic runChain(input logic [31:0] ptr, input logic dir);
    logic [31:0] v;
    regWrite(3'd3, ptr);
    regWrite(3'd4, {9'b0, dir, 14'b0, 1'b1, 7'b0});
    for (int n = 0; n < 3000; n++) begin
      regRead(3'd4, v);
      if (!v[7]) break;
    end
    chk("run ends", {31'b0, v[7]}, 0);
  endtask

  task automatic testReset();
    logic [31:0] v;
    regRead(3'd0, v); chk("R1 gctrl", v, 0);
    regRead(3'd1, v); chk("R1 ie", v, 0);
    regRead(3'd2, v); chk("R1 is", v, 0);
    regRead(3'd3, v); chk("R1 ptr", v, 0);
    regRead(3'd4, v); chk("R1 ccr", v, 0);
    regRead(3'd5, v); chk("R1 tmo", v, 16);
    chk("R1 irq", {31'b0, irq}, 0);
  endtask

  task automatic testEnable();
    logic [31:0] v;
    regWrite(3'd4, 32'h80);
    regRead(3'd4, v); chk("R2 run blocked", {31'b0, v[7]}, 0);
    regWrite(3'd0, 32'h1);
    regRead(3'd0, v); chk("R2 enable readback", v, 1);
  endtask

  task automatic testTxChain();
    logic [31:0] v;
    int base;
    putDesc(32'h000, 32'h4000_0003, 32'h100, 32'h040);
    putDesc(32'h040, 32'hC000_0002, 32'h180, 32'h000);
    regWrite(3'd1, 32'h1);
    txReady = 1'b1;
    base = sinkCnt;
    runChain(32'h000, 1'b0);
    txReady = 1'b0;
    chk("R4 byte count over chain", sinkCnt - base, 5);
    for (int k = 0; k < 3; k++) chk("R5 tx order desc0", sink[base + k], mem[32'h100 + k]);
    for (int k = 0; k < 2; k++) chk("R4 tx order desc1", sink[base + 3 + k], mem[32'h180 + k]);
    regRead(3'd4, v); chk("R6 success code", v[3:0], 15);
    regRead(3'd2, v); chk("R6 status set", v, 1);
    chk("R12 irq high", {31'b0, irq}, 1);
    regWrite(3'd2, 32'h1);
    regRead(3'd2, v); chk("R12 status cleared", v, 0);
    chk("R12 irq low", {31'b0, irq}, 0);
  endtask

  task automatic testRxWrite();
    logic [31:0] v;
    logic [7:0] pat [4];
    pat = '{8'hA5, 8'h3C, 8'h0F, 8'hF0};
    putDesc(32'h080, 32'hC000_0004, 32'h300, 32'h000);
    for (int k = 0; k < 4; k++) srcMem[(srcIdx + k) % 256] = pat[k];
    srcEnd = srcIdx + 4;
    rxOn = 1'b1;
    runChain(32'h080, 1'b1);
    rxOn = 1'b0;
    for (int k = 0; k < 4; k++) chk("R5 rx to memory", mem[32'h300 + k], pat[k]);
    regRead(3'd4, v);
    chk("R6 rx success", v[3:0], 15);
    chk("R5 dir readback", {31'b0, v[22]}, 1);
    regWrite(3'd2, 32'h1);
  endtask

  task automatic testStalls();
    logic [31:0] v;
    int base;
    regWrite(3'd5, 32'd8);
    putDesc(32'h0C0, 32'hC000_0004, 32'h100, 32'h000);
    base = sinkCnt;
    runChain(32'h0C0, 1'b0);
    regRead(3'd4, v); chk("R7 underrun code", v[3:0], 1);
    chk("R7 nothing sent", sinkCnt - base, 0);
    runChain(32'h0C0, 1'b1);
    regRead(3'd4, v); chk("R8 overrun code", v[3:0], 2);
  endtask

  task automatic testEarlyEnd();
    logic [31:0] v;
    int base;
    txReady = 1'b1;
    periphEnd = 1'b1;
    base = sinkCnt;
    runChain(32'h000, 1'b0);
    periphEnd = 1'b0;
    txReady = 1'b0;
    regRead(3'd4, v); chk("R9 early end code", v[3:0], 5);
    chk("R9 no bytes after end", sinkCnt - base, 0);
  endtask

  task automatic testFaults();
    logic [31:0] v;
    runChain(32'h800, 1'b0);
    regRead(3'd4, v); chk("R10 fetch error code", v[3:0], 3);
    putDesc(32'h0E0, 32'h8000_0002, 32'h100, 32'h000);
    runChain(32'h0E0, 1'b0);
    regRead(3'd4, v); chk("R10 format bit code", v[3:0], 3);
    putDesc(32'h0D0, 32'hC000_0002, 32'h900, 32'h000);
    txReady = 1'b1;
    runChain(32'h0D0, 1'b0);
    txReady = 1'b0;
    regRead(3'd4, v); chk("R11 buffer read error code", v[3:0], 4);
    srcEnd = srcIdx + 2;
    rxOn = 1'b1;
    runChain(32'h0D0, 1'b1);
    rxOn = 1'b0;
    regRead(3'd4, v); chk("R11 buffer write error code", v[3:0], 4);
  endtask

  task automatic testZeroClear();
    logic [31:0] v;
    regWrite(3'd4, 32'h0);
    regRead(3'd4, v); chk("R13 event cleared", v, 0);
  endtask

  task automatic testMaskAndSoftReset();
    logic [31:0] v;
    regWrite(3'd2, 32'h1);
    regWrite(3'd1, 32'h0);
    putDesc(32'h0C0, 32'hC000_0004, 32'h100, 32'h000);
    txReady = 1'b1;
    runChain(32'h0C0, 1'b0);
    txReady = 1'b0;
    regRead(3'd2, v); chk("R12 status without enable", v, 1);
    chk("R12 irq masked", {31'b0, irq}, 0);
    regWrite(3'd0, 32'h101);
    regRead(3'd4, v); chk("R3 event cleared", v[3:0], 0);
    regRead(3'd2, v); chk("R3 status cleared", v, 0);
    regRead(3'd0, v); chk("R3 enable kept by write", v, 1);
    regWrite(3'd5, 32'd1000);
    regWrite(3'd4, 32'h80);
    repeat (20) @(negedge clk);
    regRead(3'd4, v); chk("R3 running before abort", {31'b0, v[7]}, 1);
    regWrite(3'd0, 32'h101);
    regRead(3'd4, v); chk("R3 run cleared", {31'b0, v[7]}, 0);
    chk("R3 offer withdrawn", {31'b0, txValid}, 0);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 8'(i * 7 + 3);
    for (int i = 0; i < 256; i++) srcMem[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testEnable();
    testTxChain();
    testRxWrite();
    testStalls();
    testEarlyEnd();
    testFaults();
    testZeroClear();
    testMaskAndSoftReset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule